// File: doc/BRIEF.md
# Programmable Serial Protocol Framer

This block is the framing engine of a synchronous serial audio port that runs as clock master. It generates the serial bit clock, a frame-sync strobe and the transmit data line, and it samples the receive data line. Programmable inputs set the shape of every frame: the delay from enable to the first frame, where the frame sync starts and how long it lasts, how many dummy stop clocks follow the data, the clock drive/sample/idle mode, the sync polarity, whether the next sync overlaps the previous word's last bit, and what the data line does once the data is done. Words are taken from a ready/valid pop port and delivered to a ready/valid push port.

Each system clock cycle is one half-period of the serial clock. A frame carries one word, or eight words in network (time-division) mode. In network mode a per-slot mask decides which slots carry transmit data. The configuration inputs are expected to change only while the port is disabled.

Top module: `ssp_framer`

## Requirements
- R1: While `en` is low the serial clock sits at its idle level, `fsync` is at its deasserted level (the inverse of `fs_pol`), `tx_ready` and `rx_valid` are low, and both sticky flags are cleared.
- R2: `clk_mode` encodes the clock behaviour. Value 0 drives on the falling edge, samples on the rising edge and idles low. Value 1 drives on rising, samples on falling and idles low. Value 2 drives on rising, samples on falling and idles high. Value 3 drives on falling, samples on rising and idles high. While running, the clock holds the drive level in the first half of every bit and the opposite level in the second half.
- R3: When `en` is sampled high at clock edge E0, the clock stays idle until the first frame begins 2*`start_dly`+1 cycles after E0.
- R4: A word holds `word_sz`+1 bits (1 to 32), right-aligned in `tx_data`/`rx_data`. It is sent MSB first, one bit per two cycles. The bits sampled from `sdi` come back on `rx_data` with a one-cycle `rx_valid` pulse.
- R5: With `fs_rel` low, frame sync is asserted from half-period `fs_dly` of each frame for 2*`fs_wid` half-periods, at level `fs_pol`. A width of 0 gives no sync.
- R6: With `fs_rel` high, `fs_dly` is ignored. Sync is asserted for the last clock period before each frame, which is the previous word's LSB when no stop clocks are set. It stays asserted for `fs_wid` clock periods in total.
- R7: The stop count is {`stop_hi`,`stop_lo`} (0 to 31). A frame lasts 2*(words*bits + stop) cycles, and the next frame follows at once.
- R8: During stop clocks `sdo` is 0 when `eot_hold` is 0, and the last transmitted bit when it is 1.
- R9: In network mode eight slots form a frame. With `slot_en` high, a slot whose `slot_mask` bit (bit n for slot n) is 0 takes no word from the pop port and drives `sdo_oe` low.
- R10: If no word is offered when an active slot starts, `underrun` is set, stays set while enabled, and zeros are sent.
- R11: If `rx_ready` is low during an `rx_valid` pulse, the word is dropped, and `overrun` is set and stays set while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one serial half-period per cycle |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Port enable |
| net_mode | input | 1 | Eight-slot network mode |
| clk_mode | input | 2 | Clock drive/sample/idle mode |
| fs_pol | input | 1 | Asserted level of frame sync |
| fs_rel | input | 1 | Sync overlaps the previous LSB |
| eot_hold | input | 1 | Hold the last bit after data |
| start_dly | input | 3 | Clocks before the first frame |
| fs_dly | input | 7 | Sync start in half-periods |
| fs_wid | input | 6 | Sync width in clocks |
| stop_lo | input | 2 | Stop count, low part |
| stop_hi | input | 3 | Stop count, high part |
| word_sz | input | 5 | Bits per word minus one |
| slot_en | input | 1 | Apply the slot mask |
| slot_mask | input | 8 | Per-slot transmit enable |
| tx_data | input | 32 | Word to send |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | Received word pulse |
| rx_ready | input | 1 | Receiver can take the word |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data output enable |
| underrun | output | 1 | Sticky transmit underrun |
| overrun | output | 1 | Sticky receive overrun |

## Verification
A bad half-period or frame counter shows up within one frame of 2*(words*bits+stop) cycles. It appears as a frame sync shifted or stretched against its programmed window, or as a second frame that starts early or late. A bad bit or slot index corrupts the looped-back word or misplaces `sdo_oe`, which shows when that word completes. Faults in the start-up count appear on the first clock edges after enable.

// File: rtl/ssp_framer.sv
module ssp_framer #(
  parameter int MAX_W = 32,
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             net_mode,
  input  logic [1:0]       clk_mode,
  input  logic             fs_pol,
  input  logic             fs_rel,
  input  logic             eot_hold,
  input  logic [2:0]       start_dly,
  input  logic [6:0]       fs_dly,
  input  logic [5:0]       fs_wid,
  input  logic [1:0]       stop_lo,
  input  logic [2:0]       stop_hi,
  input  logic [4:0]       word_sz,
  input  logic             slot_en,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic             sdi,
  output logic             sclk,
  output logic             fsync,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             underrun,
  output logic             overrun
);
  localparam int WB  = $clog2(MAX_W);
  localparam int SB  = $clog2(SLOTS);
  localparam int FHW = $clog2(2*MAX_W*SLOTS + 2*31 + 8) + 1;

  typedef enum logic [1:0] {S_OFF, S_START, S_RUN} st_t;

  st_t              st;
  logic [3:0]       sd_cnt;
  logic [FHW-1:0]   fhc;
  logic             half;
  logic [WB-1:0]    bit_ix;
  logic [SB-1:0]    slot;
  logic [MAX_W-1:0] tx_sh, rx_sh;
  logic             last_bit, slot_on;

  logic [FHW-1:0] bits_f, nsl_f, ldata, flen, wid2, dly_f;
  logic [WB-1:0]  sh_amt;
  logic [SB-1:0]  nxt_slot;
  logic           in_data, word_end, frame_end, go, last_slot, load_now, nxt_on;
  logic           fs_on;

  assign bits_f    = FHW'(word_sz[WB-1:0]) + FHW'(1);
  assign nsl_f     = net_mode ? FHW'(SLOTS) : FHW'(1);
  assign ldata     = (bits_f * nsl_f) << 1;
  assign flen      = ldata + (FHW'({stop_hi, stop_lo}) << 1);
  assign wid2      = FHW'(fs_wid) << 1;
  assign dly_f     = FHW'(fs_dly);
  assign sh_amt    = WB'(MAX_W-1) - word_sz[WB-1:0];

  assign in_data   = (st == S_RUN) && (fhc < ldata);
  assign word_end  = in_data && half && (bit_ix == word_sz[WB-1:0]);
  assign frame_end = (st == S_RUN) && (fhc == flen - FHW'(1));
  assign go        = (st == S_START) && (sd_cnt == 4'd0);
  assign last_slot = net_mode ? (slot == SB'(SLOTS-1)) : 1'b1;
  assign load_now  = go || frame_end || (word_end && !last_slot);
  assign nxt_slot  = (go || frame_end) ? '0 : slot + SB'(1);
  assign nxt_on    = !(net_mode && slot_en) || slot_mask[nxt_slot];
  assign tx_ready  = load_now && nxt_on;

  always_comb begin
    fs_on = 1'b0;
    if (fs_wid != 6'd0) begin
      if (fs_rel)
        fs_on = ((st == S_START) && (sd_cnt <= 4'd1)) ||
                ((st == S_RUN) && ((fhc + FHW'(2) >= flen) || (fhc + FHW'(2) < wid2)));
      else
        fs_on = (st == S_RUN) && (fhc >= dly_f) && (fhc < dly_f + wid2);
    end
  end

  assign sclk     = (st == S_RUN) ? (half ^ (clk_mode[0] ^ clk_mode[1])) : clk_mode[1];
  assign fsync    = fs_on ? fs_pol : ~fs_pol;
  assign sdo      = in_data ? tx_sh[MAX_W-1] : (eot_hold & last_bit);
  assign sdo_oe   = !in_data || slot_on;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign underrun = underrun_q;
  assign overrun  = overrun_q;

  logic             rx_valid_q, underrun_q, overrun_q;
  logic [MAX_W-1:0] rx_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; sd_cnt <= '0; fhc <= '0; half <= 1'b0; bit_ix <= '0; slot <= '0;
      tx_sh <= '0; rx_sh <= '0; last_bit <= 1'b0; slot_on <= 1'b1;
      rx_valid_q <= 1'b0; rx_data_q <= '0; underrun_q <= 1'b0; overrun_q <= 1'b0;
    end else if (!en) begin
      st <= S_OFF; sd_cnt <= '0; fhc <= '0; half <= 1'b0; bit_ix <= '0; slot <= '0;
      tx_sh <= '0; rx_sh <= '0; last_bit <= 1'b0; slot_on <= 1'b1;
      rx_valid_q <= 1'b0; underrun_q <= 1'b0; overrun_q <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          st <= S_START;
          sd_cnt <= {start_dly, 1'b0};
        end
        S_START: if (go) st <= S_RUN; else sd_cnt <= sd_cnt - 4'd1;
        default: begin
          half <= ~half;
          fhc  <= frame_end ? '0 : fhc + FHW'(1);
          if (frame_end || word_end) bit_ix <= '0;
          else if (in_data && half) bit_ix <= bit_ix + WB'(1);
          if (frame_end) slot <= '0;
          else if (word_end && !last_slot) slot <= slot + SB'(1);
        end
      endcase

      if (in_data && half) last_bit <= tx_sh[MAX_W-1];
      if (load_now) begin
        slot_on <= nxt_on;
        tx_sh   <= (nxt_on && tx_valid) ? (tx_data << sh_amt) : '0;
        if (nxt_on && !tx_valid) underrun_q <= 1'b1;
      end else if (in_data && half) begin
        tx_sh <= tx_sh << 1;
      end

      if (in_data && !half) rx_sh <= {rx_sh[MAX_W-2:0], sdi};
      rx_valid_q <= word_end;
      if (word_end) rx_data_q <= rx_sh & ({MAX_W{1'b1}} >> sh_amt);
      if (rx_valid_q && !rx_ready) overrun_q <= 1'b1;
    end
  end

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == clk_mode[1]) && (fsync == ~fs_pol) && !underrun && !overrun);
  p_sclk_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_RUN) |=> (sclk != $past(sclk)));
  p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_oe_only_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> (net_mode && slot_en));
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && underrun) |=> underrun);
  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && overrun) |=> overrun);
endmodule

// File: tb/ssp_framer_tb.sv
module ssp_framer_tb_top;
  typedef struct packed {
    logic [1:0]  mode;
    logic        pol, rel, eot;
    logic [2:0]  sdly;
    logic [6:0]  fdly;
    logic [5:0]  fwid;
    logic [4:0]  dstop;
    logic [4:0]  wsz;
    logic [31:0] word;
  } vec_t;

  localparam int NV = 6;
  localparam int NT = 400;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 7'd0, 6'd1, 5'd0,  5'd7,  32'h000000A5},
    '{2'd1, 1'b0, 1'b0, 1'b1, 3'd2, 7'd3, 6'd2, 5'd2,  5'd15, 32'h00001235},
    '{2'd2, 1'b1, 1'b1, 1'b0, 3'd1, 7'd0, 6'd1, 5'd0,  5'd7,  32'h0000003C},
    '{2'd3, 1'b1, 1'b1, 1'b1, 3'd3, 7'd5, 6'd3, 5'd5,  5'd11, 32'h00000ABC},
    '{2'd0, 1'b0, 1'b0, 1'b1, 3'd7, 7'd9, 6'd4, 5'd31, 5'd31, 32'hDEADBEEF},
    '{2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, 6'd1, 5'd3,  5'd0,  32'h00000001}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, net_mode = 1'b0;
  logic [1:0] clk_mode = 2'd0;
  logic fs_pol = 1'b1, fs_rel = 1'b0, eot_hold = 1'b0;
  logic [2:0] start_dly = 3'd0;
  logic [6:0] fs_dly = 7'd0;
  logic [5:0] fs_wid = 6'd1;
  logic [1:0] stop_lo = 2'd0;
  logic [2:0] stop_hi = 3'd0;
  logic [4:0] word_sz = 5'd7;
  logic slot_en = 1'b0;
  logic [7:0] slot_mask = 8'hFF;
  logic [31:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic tx_ready, rx_valid, sclk, fsync, sdo, sdo_oe, underrun, overrun;
  logic [31:0] rx_data;

  int n_chk = 0, n_fail = 0;
  logic tr_sclk [NT], tr_fs [NT], tr_sdo [NT], tr_oe [NT], tr_hs [NT];
  logic [31:0] rx_cap;
  logic rx_got;

  always #4 clk = ~clk;

  ssp_framer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .net_mode(net_mode), .clk_mode(clk_mode),
    .fs_pol(fs_pol), .fs_rel(fs_rel), .eot_hold(eot_hold), .start_dly(start_dly),
    .fs_dly(fs_dly), .fs_wid(fs_wid), .stop_lo(stop_lo), .stop_hi(stop_hi),
    .word_sz(word_sz), .slot_en(slot_en), .slot_mask(slot_mask), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .sdi(sdo), .sclk(sclk), .fsync(fsync), .sdo(sdo),
    .sdo_oe(sdo_oe), .underrun(underrun), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_port(input int n);
    rx_got = 1'b0; rx_cap = '0;
    @(negedge clk) en = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      tr_sclk[t] = sclk; tr_fs[t] = fsync; tr_sdo[t] = sdo; tr_oe[t] = sdo_oe;
      tr_hs[t] = tx_ready && tx_valid;
      if (rx_valid && !rx_got) begin rx_got = 1'b1; rx_cap = rx_data; end
    end
  endtask

  task automatic stop_port();
    @(negedge clk) en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(sclk == 1'b0 && fsync == 1'b0 && sdo == 1'b0, "R1 reset pins",
        {sclk, fsync, sdo}, 3'b000);
    chk(!tx_ready && !rx_valid && !underrun && !overrun, "R1 reset handshake/flags",
        {tx_ready, rx_valid, underrun, overrun}, 0);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t c = VECS[v];
      automatic int bits = int'(c.wsz) + 1;
      automatic int t0 = 2 * int'(c.sdly) + 1;
      automatic int L = 2 * (bits + int'(c.dstop));
      automatic logic idle = c.mode[1];
      automatic logic drv = c.mode[0] ^ c.mode[1];
      automatic bit ok;
      automatic int bad;
      clk_mode = c.mode; fs_pol = c.pol; fs_rel = c.rel; eot_hold = c.eot;
      start_dly = c.sdly; fs_dly = c.fdly; fs_wid = c.fwid;
      stop_lo = c.dstop[1:0]; stop_hi = c.dstop[4:2]; word_sz = c.wsz;
      net_mode = 1'b0; slot_en = 1'b0; tx_data = c.word; tx_valid = 1'b1; rx_ready = 1'b1;
      run_port(NT);

      // R3: idle until the first frame, first toggle one cycle into it
      ok = 1; bad = -1;
      for (int t = 0; t < t0; t++) if (tr_sclk[t] != idle) begin ok = 0; bad = t; end
      if (tr_sclk[t0+1] != !drv) begin ok = 0; bad = t0 + 1; end
      chk(ok, $sformatf("R3 start delay vec%0d t=%0d", v, bad), bad, t0);

      // R2: running clock waveform
      ok = 1; bad = -1;
      for (int t = t0; t < t0 + 2*L; t++)
        if (tr_sclk[t] != (((t - t0) % 2 == 0) ? drv : !drv)) begin ok = 0; bad = t; end
      chk(ok, $sformatf("R2 clock mode %0d vec%0d t=%0d", c.mode, v, bad), bad, -1);

      // R4: MSB-first data and loopback word
      ok = 1; bad = -1;
      for (int i = 0; i < bits; i++) begin
        if (tr_sdo[t0+2*i] != c.word[bits-1-i] || tr_sdo[t0+2*i+1] != c.word[bits-1-i]) begin
          ok = 0; bad = i;
        end
      end
      chk(ok, $sformatf("R4 tx bits vec%0d bit=%0d", v, bad), bad, -1);
      chk(rx_got && rx_cap == c.word, $sformatf("R4 rx word vec%0d", v), rx_cap, c.word);

      // R7: second frame repeats the word after the full frame length
      ok = 1; bad = -1;
      for (int i = 0; i < bits; i++)
        if (tr_sdo[t0+L+2*i] != c.word[bits-1-i]) begin ok = 0; bad = i; end
      chk(ok, $sformatf("R7 frame length vec%0d bit=%0d", v, bad), bad, -1);

      // R8: stop clocks carry the end-of-transfer state
      if (c.dstop != 0) begin
        ok = 1; bad = -1;
        for (int t = t0 + 2*bits; t < t0 + L; t++)
          if (tr_sdo[t] != (c.eot & c.word[0])) begin ok = 0; bad = t; end
        chk(ok, $sformatf("R8 stop data vec%0d t=%0d", v, bad), bad, -1);
      end

      // R5 / R6: frame sync window and polarity
      ok = 1; bad = -1;
      for (int t = 0; t < t0 + 2*L; t++) begin
        automatic bit act = 0;
        automatic int p = (t >= t0) ? (t - t0) % L : -1;
        if (c.fwid != 0) begin
          if (c.rel) act = (t < t0) ? (t >= t0 - 2) : (p >= L - 2 || p + 2 < 2*int'(c.fwid));
          else       act = (t >= t0) && (p >= int'(c.fdly)) && (p < int'(c.fdly) + 2*int'(c.fwid));
        end
        if (tr_fs[t] != (act ? c.pol : !c.pol)) begin ok = 0; bad = t; end
      end
      chk(ok, $sformatf("%s frame sync vec%0d t=%0d", c.rel ? "R6" : "R5", v, bad), bad, -1);

      stop_port();
    end

    // R9: network mode, slots 0 and 2 active, 4-bit words
    clk_mode = 2'd0; fs_pol = 1'b1; fs_rel = 1'b0; eot_hold = 1'b0; start_dly = 3'd0;
    fs_dly = 7'd0; fs_wid = 6'd1; stop_lo = 2'd0; stop_hi = 3'd0; word_sz = 5'd3;
    net_mode = 1'b1; slot_en = 1'b1; slot_mask = 8'b0000_0101; tx_data = 32'h9; tx_valid = 1'b1;
    run_port(120);
    begin
      automatic int hs = 0;
      automatic bit ok0 = 1, ok1 = 1, okd = 1;
      for (int t = 0; t <= 62; t++) if (tr_hs[t]) hs++;
      for (int t = 1; t < 9; t++) if (!tr_oe[t]) ok0 = 0;
      for (int t = 9; t < 17; t++) if (tr_oe[t]) ok1 = 0;
      for (int i = 0; i < 4; i++) if (tr_sdo[17+2*i] != tx_data[3-i] || !tr_oe[17+2*i]) okd = 0;
      chk(ok0, "R9 active slot0 output enable", ok0, 1);
      chk(ok1, "R9 masked slot1 output released", ok1, 1);
      chk(okd, "R9 slot2 data", okd, 1);
      chk(hs == 2, "R9 words taken per frame", hs, 2);
      chk(tr_fs[9] == 1'b0 && tr_fs[1] == 1'b1, "R9 one sync per frame",
          {tr_fs[1], tr_fs[9]}, 2'b10);
    end
    stop_port();
    net_mode = 1'b0; slot_en = 1'b0; slot_mask = 8'hFF;

    // R10: underrun
    word_sz = 5'd7; tx_valid = 1'b0;
    run_port(40);
    begin
      automatic bit z = 1;
      for (int t = 1; t < 17; t++) if (tr_sdo[t]) z = 0;
      chk(underrun == 1'b1, "R10 underrun set", underrun, 1);
      chk(z, "R10 zeros sent", z, 1);
    end
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    // R1: disable clears flags, idles the pins
    chk(underrun == 1'b0 && sclk == 1'b0 && fsync == 1'b0 && !tx_ready, "R1 disable state",
        {underrun, sclk, fsync, tx_ready}, 0);
    repeat (2) @(negedge clk);

    // R11: overrun
    tx_valid = 1'b1; rx_ready = 1'b0; tx_data = 32'h5A;
    run_port(40);
    chk(overrun == 1'b1 && underrun == 1'b0, "R11 overrun set", {overrun, underrun}, 2'b10);
    stop_port();
    chk(overrun == 1'b0, "R1 overrun cleared on disable", overrun, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule